// File: doc/BRIEF.md
# Interrupt Entry Context Save Sequencer

This block carries out the fixed processor-side work that follows the acceptance of a maskable interrupt, and the matching return. When the interrupt controller acknowledges a source, the sequencer saves the restart PC and then the status word into two dedicated save registers. It writes an exception code into the low half of the cause register, marks the status word as "in interrupt" and "not in exception", and redirects fetch to the handler slot of that source. It spends one clock cycle on each of these five steps and reports busy until the last one is done.

A return command puts back the PC and status word from the save registers in a single cycle and pulses a return strobe towards the interrupt controller. There is only one pair of save registers. A nested acceptance overwrites them, so a handler that re-enables interrupts has to store them away first. The cause and status registers live outside the block. The block presents write strobes and write data for them, and takes the current upper cause half as an input so that this half passes through unchanged.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `cause_we`, `psw_we`, `redir_valid` and `ret_pulse` are 0, and `eipc` and `eipsw` read 0.
- R2: An `ack_valid` sampled while `busy` is 0 is accepted. In the next cycle `eipc` holds the `cur_pc` sampled at acceptance and `busy` is 1. A later acceptance overwrites `eipc` again.
- R3: In the cycle after acceptance, the block samples `cur_psw` into `eipsw` at the clock edge. `eipsw` then holds that value from the third cycle on.
- R4: In the third cycle `cause_we` is 1 for exactly one cycle. `cause_wdata[15:0]` is CODE_BASE + 16·src and `cause_wdata[31:16]` equals `cause_hi` of that cycle.
- R5: In the fourth cycle `psw_we` is 1 and `psw_wdata` equals `eipsw` with bit 5 (in-interrupt) forced to 1, bit 6 (in-exception) forced to 0, and every other bit unchanged.
- R6: In the fifth cycle `redir_valid` is 1 with `redir_pc` = VEC_BASE + 16·src. In the following cycle `busy` is 0.
- R7: `busy` stays 1 from the cycle after acceptance through the fifth cycle. An `ack_valid` seen during that time is ignored: `eipc`, the code and the handler of the running sequence are unaffected.
- R8: A `ret_req` sampled while idle causes, in the next cycle only, `ret_pulse` = 1, `redir_valid` = 1 with `redir_pc` = `eipc`, and `psw_we` = 1 with `psw_wdata` = `eipsw`.
- R9: A `ret_req` sampled while `busy` is 1 is ignored. When `ack_valid` and `ret_req` are both sampled while idle, the acknowledge is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_valid | input | 1 | Interrupt acknowledge from the controller |
| ack_src | input | SRC_W | Index of the acknowledged source |
| ret_req | input | 1 | Return-from-interrupt command |
| cur_pc | input | 32 | Restart PC of the interrupted flow |
| cur_psw | input | 32 | Current status word |
| cause_hi | input | 16 | Current upper half of the cause register |
| eipc | output | 32 | Saved PC register |
| eipsw | output | 32 | Saved status word register |
| busy | output | 1 | Sequence or return in progress |
| cause_we | output | 1 | Cause register write strobe |
| cause_wdata | output | 32 | Cause register write data |
| psw_we | output | 1 | Status word write strobe |
| psw_wdata | output | 32 | Status word write data |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_pc | output | 32 | Fetch redirect target |
| ret_pulse | output | 1 | Return notification to the controller |

## Verification
The assertions assume that `cur_pc` and `cur_psw` are sampled only at the edges where the sequence takes them, so they may change freely in between. They also assume that acknowledges and returns arrive at any time, including while busy. The stimulus therefore changes `cur_psw` between acceptance and the status capture, and it raises `ack_valid` and `ret_req` in the middle of a sequence. It also presents both requests together while idle, and it sweeps every source index in the default four-bit configuration with distinct PC, status and cause values for each.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int WORD_W     = 32;
    localparam int PSW_ID_BIT = 5;
    localparam int PSW_EP_BIT = 6;
    localparam int SLOT_SHIFT = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PSW,
        ST_CAUSE,
        ST_STAT,
        ST_JUMP,
        ST_RET
    } seq_state_e;

    function automatic word_t entry_psw(input word_t psw);
        word_t r;
        r = psw;
        r[PSW_ID_BIT] = 1'b1;
        r[PSW_EP_BIT] = 1'b0;
        return r;
    endfunction

    function automatic word_t slot_addr(input word_t base, input word_t idx);
        return base + (idx << SLOT_SHIFT);
    endfunction

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack_valid,
    input  logic       ret_req,
    output seq_state_e state,
    output logic       accept,
    output logic       busy
);

    localparam int MAX_BUSY = 4;

    seq_state_e state_nx;

    assign busy   = (state != ST_IDLE);
    assign accept = (state == ST_IDLE) && ack_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (ack_valid)    state_nx = ST_PSW;
                      else if (ret_req) state_nx = ST_RET;
            ST_PSW:   state_nx = ST_CAUSE;
            ST_CAUSE: state_nx = ST_STAT;
            ST_STAT:  state_nx = ST_JUMP;
            ST_JUMP:  state_nx = ST_IDLE;
            ST_RET:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Busy-length watch: a window counter instead of a long $past chain.
    logic [2:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 3'd1;
    end

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < 3'(MAX_BUSY)));

    assert_busy_after_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && ack_valid) |=> busy);

endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs
    import irq_entry_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             psw_cap,
    input  logic [SRC_W-1:0] ack_src,
    input  word_t            cur_pc,
    input  word_t            cur_psw,
    output word_t            eipc,
    output word_t            eipsw,
    output logic [SRC_W-1:0] src_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            eipc  <= '0;
            src_q <= '0;
        end else if (accept) begin
            eipc  <= cur_pc;
            src_q <= ack_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          eipsw <= '0;
        else if (psw_cap) eipsw <= cur_psw;
    end

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
    import irq_entry_pkg::*;
#(
    parameter int          SRC_W     = 4,
    parameter logic [15:0] CODE_BASE = 16'h0080,
    parameter word_t       VEC_BASE  = 32'h0000_1000
) (
    input  logic [SRC_W-1:0] src,
    input  logic [15:0]      cause_hi,
    output word_t            cause_word,
    output word_t            handler
);

    localparam int PAD_W = WORD_W - SRC_W;

    word_t idx;
    word_t code_full;

    assign idx        = {{PAD_W{1'b0}}, src};
    assign code_full  = slot_addr({16'h0000, CODE_BASE}, idx);
    assign cause_word = {cause_hi, code_full[15:0]};
    assign handler    = slot_addr(VEC_BASE, idx);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int          SRC_W     = 4,
    parameter logic [15:0] CODE_BASE = 16'h0080,
    parameter logic [31:0] VEC_BASE  = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_valid,
    input  logic [SRC_W-1:0] ack_src,
    input  logic             ret_req,
    input  logic [31:0]      cur_pc,
    input  logic [31:0]      cur_psw,
    input  logic [15:0]      cause_hi,
    output logic [31:0]      eipc,
    output logic [31:0]      eipsw,
    output logic             busy,
    output logic             cause_we,
    output logic [31:0]      cause_wdata,
    output logic             psw_we,
    output logic [31:0]      psw_wdata,
    output logic             redir_valid,
    output logic [31:0]      redir_pc,
    output logic             ret_pulse
);

    seq_state_e       state;
    logic             accept;
    logic [SRC_W-1:0] src_q;
    word_t            cause_word;
    word_t            handler;

    irq_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ack_valid (ack_valid),
        .ret_req   (ret_req),
        .state     (state),
        .accept    (accept),
        .busy      (busy)
    );

    irq_save_regs #(.SRC_W(SRC_W)) u_save (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .psw_cap (state == ST_PSW),
        .ack_src (ack_src),
        .cur_pc  (cur_pc),
        .cur_psw (cur_psw),
        .eipc    (eipc),
        .eipsw   (eipsw),
        .src_q   (src_q)
    );

    irq_vec_gen #(
        .SRC_W     (SRC_W),
        .CODE_BASE (CODE_BASE),
        .VEC_BASE  (VEC_BASE)
    ) u_vec (
        .src        (src_q),
        .cause_hi   (cause_hi),
        .cause_word (cause_word),
        .handler    (handler)
    );

    always_comb begin
        cause_we    = (state == ST_CAUSE);
        cause_wdata = cause_word;
        ret_pulse   = (state == ST_RET);
        psw_we      = (state == ST_STAT) || ret_pulse;
        psw_wdata   = ret_pulse ? eipsw : entry_psw(eipsw);
        redir_valid = (state == ST_JUMP) || ret_pulse;
        redir_pc    = ret_pulse ? eipc : handler;
    end

    assert_eipc_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && ack_valid) |=> (eipc == $past(cur_pc)));

    assert_eipsw_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && ack_valid) |=> ##1 (eipsw == $past(cur_psw)));

    assert_cause_then_psw_R4: assert property (@(posedge clk) disable iff (rst)
        cause_we |=> (psw_we && !ret_pulse && !cause_we));

    assert_entry_psw_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (psw_we && !ret_pulse) |-> (psw_wdata[5] && !psw_wdata[6] &&
                                    (((psw_wdata ^ eipsw) & ~32'h0000_0060) == 32'h0)));

    assert_jump_then_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && !ret_pulse) |=> !busy);

    assert_eipc_held_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(eipc));

    assert_ret_restore_R8: assert property (@(posedge clk) disable iff (rst)
        ret_pulse |-> (redir_valid && psw_we && redir_pc == eipc && psw_wdata == eipsw));

    assert_ack_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && ack_valid && ret_req) |=> !ret_pulse);

    assert_strobes_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cause_we, psw_we & ~ret_pulse, redir_valid & ~ret_pulse, ret_pulse}));

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    localparam int          CLK_PERIOD = 10;
    localparam int          SRC_W      = 4;
    localparam logic [15:0] CODE_BASE  = 16'h0080;
    localparam logic [31:0] VEC_BASE   = 32'h0000_1000;

    logic             clk = 1'b0;
    logic             rst;
    logic             ack_valid;
    logic [SRC_W-1:0] ack_src;
    logic             ret_req;
    logic [31:0]      cur_pc, cur_psw;
    logic [15:0]      cause_hi;
    logic [31:0]      eipc, eipsw, cause_wdata, psw_wdata, redir_pc;
    logic             busy, cause_we, psw_we, redir_valid, ret_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq #(
        .SRC_W(SRC_W), .CODE_BASE(CODE_BASE), .VEC_BASE(VEC_BASE)
    ) i_irq_entry_seq (
        .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_src(ack_src),
        .ret_req(ret_req), .cur_pc(cur_pc), .cur_psw(cur_psw), .cause_hi(cause_hi),
        .eipc(eipc), .eipsw(eipsw), .busy(busy), .cause_we(cause_we),
        .cause_wdata(cause_wdata), .psw_we(psw_we), .psw_wdata(psw_wdata),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .ret_pulse(ret_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobes_idle(input string req);
        chk(req, {27'd0, busy, cause_we, psw_we, redir_valid, ret_pulse}, 32'd0);
    endtask

    // Full entry sequence for source s; optional disturbances mid-sequence.
    task automatic run_entry(input int s, input logic [31:0] pc, input logic [31:0] psw,
                             input logic [15:0] chi, input bit poke_ack, input bit poke_ret);
        logic [31:0] exp_code, exp_vec, exp_psw;
        exp_code = {chi, CODE_BASE + 16'(s * 16)};
        exp_vec  = VEC_BASE + 32'(s * 16);
        exp_psw  = (psw | 32'h20) & ~32'h40;
        ack_valid = 1'b1; ack_src = SRC_W'(s); cur_pc = pc; cur_psw = ~psw;
        @(negedge clk);
        ack_valid = 1'b0; cur_pc = ~pc; cur_psw = psw; cause_hi = chi;
        chk("R2 eipc captured", eipc, pc);
        chk("R2 busy after accept", {31'd0, busy}, 32'd1);
        @(negedge clk);
        cur_psw = 32'hDEAD_0000;
        if (poke_ack) begin ack_valid = 1'b1; ack_src = SRC_W'(s + 1); cur_pc = 32'h0BAD_0000; end
        if (poke_ret) ret_req = 1'b1;
        chk("R3 eipsw captured", eipsw, psw);
        chk("R4 cause_we", {31'd0, cause_we}, 32'd1);
        chk("R4 cause_wdata", cause_wdata, exp_code);
        @(negedge clk);
        chk("R4 cause_we one cycle", {31'd0, cause_we}, 32'd0);
        chk("R5 psw_we", {31'd0, psw_we}, 32'd1);
        chk("R5 psw_wdata", psw_wdata, exp_psw);
        chk("R7 busy held", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R6 redir_valid", {31'd0, redir_valid}, 32'd1);
        chk("R6 redir_pc", redir_pc, exp_vec);
        chk("R7 eipc unaffected", eipc, pc);
        chk("R9 no ret during busy", {31'd0, ret_pulse}, 32'd0);
        ack_valid = 1'b0; ret_req = 1'b0;
        @(negedge clk);
        strobes_idle("R6 idle after step five");
        chk("R7 eipsw kept", eipsw, psw);
    endtask

    task automatic run_return(input logic [31:0] pc, input logic [31:0] psw);
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk("R8 ret_pulse", {31'd0, ret_pulse}, 32'd1);
        chk("R8 redir_valid", {31'd0, redir_valid}, 32'd1);
        chk("R8 redir_pc", redir_pc, pc);
        chk("R8 psw_we", {31'd0, psw_we}, 32'd1);
        chk("R8 psw_wdata", psw_wdata, psw);
        @(negedge clk);
        strobes_idle("R8 return one cycle");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ack_valid = 1'b0; ack_src = '0; ret_req = 1'b0;
        cur_pc = '0; cur_psw = '0; cause_hi = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        strobes_idle("R1 reset strobes");
        chk("R1 reset eipc", eipc, 32'd0);
        chk("R1 reset eipsw", eipsw, 32'd0);

        // Sweep every source with distinct values.
        for (int s = 0; s < (1 << SRC_W); s++) begin
            logic [31:0] pc, psw;
            pc  = 32'h0001_0000 + 32'(s * 32'h0000_0104);
            psw = 32'hA5A5_0000 ^ 32'(s * 32'h0101_0041);
            run_entry(s, pc, psw, 16'(16'h1000 + s * 16'h0111), (s % 3) == 1, (s % 4) == 2);
            run_return(pc, psw);
        end

        // Status word with both flag bits preset / cleared.
        run_entry(5, 32'h0000_4000, 32'h0000_0040, 16'hFFFF, 1'b0, 1'b0);
        run_entry(9, 32'h0000_8000, 32'hFFFF_FFBF, 16'h0000, 1'b0, 1'b0);
        chk("R2 nested overwrite eipc", eipc, 32'h0000_8000);
        run_return(32'h0000_8000, 32'hFFFF_FFBF);

        // Acknowledge and return together: acknowledge wins (R9).
        ret_req = 1'b1;
        run_entry(3, 32'h0000_C000, 32'h1234_5678, 16'hABCD, 1'b0, 1'b0);
        chk("R9 ack wins, no return", {31'd0, ret_pulse}, 32'd0);
        run_return(32'h0000_C000, 32'h1234_5678);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule